// File: doc/BRIEF.md
# Hiccup-Mode Overcurrent Retry Controller

This block decides, cycle by cycle, whether a linear regulator is running normally, running with its current clamped, or switched off for a cool-down. It takes a one-bit overcurrent flag, which may come from a sense-resistor comparator or from a saturated output driver; both sources are handled the same way. The flag is resynchronized through two flops. When it asserts, the regulator stays on in a clamped phase for a fixed interval. If the flag clears within that interval, normal operation resumes. If the flag is still set when the interval ends, the regulator is switched off for a longer retry interval. It is then switched back on into another clamped probe interval. This loop repeats for as long as the fault persists.

Both intervals are parameters counted in system clocks. A saturating counter records how many times the regulator has been shut down. Dropping the enable input forces the regulator off and clears the phase timer.

Top module: `ocp_retry_ctrl`

## Requirements
- R1: While reset is low at a clock edge, after that edge `reg_on`, `limiting` and `fault` are 0 and `fault_count` is 0.
- R2: With `en` high and no overcurrent, `reg_on` goes to 1 one clock after the regulator leaves the disabled state.
- R3: `oc_in` passes through two synchronizing flops. `limiting` rises on the third rising edge after `oc_in` is raised, and `reg_on` stays 1.
- R4: If the synchronized overcurrent clears while `limiting` is 1, `limiting` drops and `reg_on` stays 1.
- R5: If overcurrent stays set for LIMIT_CYCLES clocks of limiting, the regulator turns off (`reg_on`=0, `fault`=1).
- R6: `fault` lasts exactly RETRY_CYCLES clocks. After that, `reg_on` and `limiting` return to 1 for a new probe interval.
- R7: `fault_count` rises by one on each entry into the off phase and saturates at its all-ones value.
- R8: With `en` low at a clock edge, after that edge `reg_on`, `limiting` and `fault` are 0 and the phase timer is cleared. `fault_count` keeps its value.
- R9: `limiting` is 1 only while `reg_on` is 1, and `fault` is 1 only while `reg_on` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Regulator enable request |
| oc_in | input | 1 | Asynchronous overcurrent flag (comparator or driver saturation) |
| reg_on | output | 1 | Regulator enable drive |
| limiting | output | 1 | Current clamp active |
| fault | output | 1 | Off phase of the retry loop |
| fault_count | output | FCNT_W | Saturating count of shutdowns |

## Verification
Short overcurrent pulses that end inside the clamp interval show that a transient fault clears without a shutdown. A flag held past the clamp interval shows the exact shutdown and retry-probe timing. A flag held for many periods shows the repeating hiccup loop and the counter saturating. Random on/off stretches of overcurrent, mixed with random enable drops, are compared every cycle against a bench model. These patterns separate an early or late phase change, a missing synchronizer stage, and a timer left running after a disable.

// File: rtl/ocp_pkg.sv
// Shared types for the overcurrent retry controller.
package ocp_pkg;
    typedef enum logic [1:0] {
        PH_IDLE  = 2'd0,  // regulator disabled
        PH_RUN   = 2'd1,  // normal operation
        PH_CLAMP = 2'd2,  // current limited, regulator still on
        PH_COOL  = 2'd3   // regulator off, waiting to retry
    } phase_t;
endpackage

// File: rtl/ocp_sync2.sv
// Two-flop synchronizer for a single asynchronous level.
// Assumes the input is a slow level; no pulse stretching.
module ocp_sync2 (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic stage1;

    // shift the level through two flops, cleared by reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage1 <= 1'b0;
            q_sync <= 1'b0;
        end else begin
            stage1 <= d_async;
            q_sync <= stage1;
        end
    end
endmodule

// File: rtl/ocp_phase_timer.sv
// Down-counter that times the clamp and cool-down phases.
// A load has priority over the count-down. Clear has priority over everything.
// The counter stops at zero.
module ocp_phase_timer #(
    parameter int TW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          load,
    input  logic [TW-1:0] load_val,
    output logic          expired
);
    logic [TW-1:0] remain;

    // load, clear or step the remaining-cycle count
    always_ff @(posedge clk) begin
        if (!rst_n || clear)     remain <= '0;
        else if (load)           remain <= load_val;
        else if (remain != '0)   remain <= remain - 1'b1;
    end

    assign expired = (remain == '0);

    // R6: once expired and not reloaded, the timer stays at zero
    a_r6_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (expired && !load) |=> expired);
endmodule

// File: rtl/ocp_fault_counter.sv
// Saturating counter of shutdown events.
// Assumes inc is a single-cycle pulse on each entry into the off phase.
module ocp_fault_counter #(
    parameter int CW = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          inc,
    output logic [CW-1:0] count
);
    localparam logic [CW-1:0] TOP = '1;

    // count up on each event, hold at the top value
    always_ff @(posedge clk) begin
        if (!rst_n)                    count <= '0;
        else if (inc && count != TOP)  count <= count + 1'b1;
    end

    // R7: a saturated counter never wraps back
    a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        (count == TOP) |=> (count == TOP));
endmodule

// File: rtl/ocp_retry_ctrl.sv
// Hiccup-mode overcurrent controller for a linear regulator.
// An asserted overcurrent flag starts a clamped phase of LIMIT_CYCLES clocks.
// If the flag persists, the regulator is switched off for RETRY_CYCLES clocks
// and then re-enabled into a new clamped probe. Enable low forces the off state.
// Assumes LIMIT_CYCLES >= 1 and RETRY_CYCLES >= 1.
module ocp_retry_ctrl #(
    parameter int LIMIT_CYCLES = 10000,
    parameter int RETRY_CYCLES = 100000,
    parameter int FCNT_W       = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              oc_in,
    output logic              reg_on,
    output logic              limiting,
    output logic              fault,
    output logic [FCNT_W-1:0] fault_count
);
    import ocp_pkg::*;

    localparam int MAXC = (LIMIT_CYCLES > RETRY_CYCLES) ? LIMIT_CYCLES : RETRY_CYCLES;
    localparam int TW   = $clog2(MAXC + 1);
    localparam logic [TW-1:0] LIM_LD = TW'(LIMIT_CYCLES - 1);
    localparam logic [TW-1:0] RET_LD = TW'(RETRY_CYCLES - 1);

    phase_t        phase, phase_nx;
    logic          oc_s;
    logic          t_load, t_expired, shut_evt;
    logic [TW-1:0] t_val;
    logic          past_ok;

    ocp_sync2 u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (oc_in),
        .q_sync  (oc_s)
    );

    ocp_phase_timer #(.TW(TW)) u_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (!en),
        .load     (t_load),
        .load_val (t_val),
        .expired  (t_expired)
    );

    ocp_fault_counter #(.CW(FCNT_W)) u_fcnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (shut_evt),
        .count (fault_count)
    );

    // next phase, timer reload and shutdown event
    always_comb begin
        phase_nx = phase;
        t_load   = 1'b0;
        t_val    = LIM_LD;
        shut_evt = 1'b0;
        if (!en) begin
            phase_nx = PH_IDLE;
        end else begin
            unique case (phase)
                PH_IDLE:  phase_nx = PH_RUN;
                PH_RUN: if (oc_s) begin
                    phase_nx = PH_CLAMP;
                    t_load   = 1'b1;
                end
                PH_CLAMP: if (!oc_s) begin
                    phase_nx = PH_RUN;
                end else if (t_expired) begin
                    phase_nx = PH_COOL;
                    t_load   = 1'b1;
                    t_val    = RET_LD;
                    shut_evt = 1'b1;
                end
                PH_COOL: if (t_expired) begin
                    phase_nx = PH_CLAMP;
                    t_load   = 1'b1;
                end
                default:  phase_nx = PH_IDLE;
            endcase
        end
    end

    // phase register
    always_ff @(posedge clk) begin
        if (!rst_n) phase <= PH_IDLE;
        else        phase <= phase_nx;
    end

    // marks that one reset cycle has been seen, for $past-based checks
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b1;
    end

    assign reg_on   = (phase == PH_RUN) || (phase == PH_CLAMP);
    assign limiting = (phase == PH_CLAMP);
    assign fault    = (phase == PH_COOL);

    // R9: clamp only while on, fault only while off
    a_r9_clamp_on: assert property (@(posedge clk) disable iff (!rst_n)
        limiting |-> reg_on);
    a_r9_fault_off: assert property (@(posedge clk) disable iff (!rst_n)
        fault |-> !reg_on);
    // R8: enable low forces every output low
    a_r8_disable_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en |=> (!reg_on && !limiting && !fault));
    // R5: the off phase is entered only from the clamp phase
    a_r5_off_from_clamp: assert property (@(posedge clk) disable iff (!rst_n || past_ok !== 1'b1)
        $rose(fault) |-> $past(limiting));
    // R7: the shutdown count moves by at most one step
    a_r7_single_step: assert property (@(posedge clk) disable iff (!rst_n || past_ok !== 1'b1)
        (fault_count != $past(fault_count)) |-> (fault_count == $past(fault_count) + 1'b1));
endmodule

// File: tb/ocp_retry_ctrl_bench.sv
// Bench: directed corner cases, then random overcurrent and enable patterns
// compared every cycle against a model built from the requirements.
module ocp_retry_ctrl_bench;
    localparam int CLK_PERIOD = 10;
    localparam int LIM = 10;
    localparam int RET = 40;
    localparam int CW  = 3;
    localparam int CMAX = (1 << CW) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic en = 1'b0;
    logic oc_in = 1'b0;
    logic reg_on, limiting, fault;
    logic [CW-1:0] fault_count;

    int n_tests = 0;
    int n_fail  = 0;
    bit cmp_on  = 1'b0;
    bit done    = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    ocp_retry_ctrl #(.LIMIT_CYCLES(LIM), .RETRY_CYCLES(RET), .FCNT_W(CW)) u_ocp_retry_ctrl (
        .clk(clk), .rst_n(rst_n), .en(en), .oc_in(oc_in),
        .reg_on(reg_on), .limiting(limiting), .fault(fault), .fault_count(fault_count)
    );

    // reference model: 0 idle, 1 run, 2 clamp, 3 cool
    int m_ph = 0, m_left = 0, m_cnt = 0;
    bit m_s1 = 0, m_s2 = 0;

    function automatic int exp_on(int ph);    return (ph == 1 || ph == 2) ? 1 : 0; endfunction
    function automatic int exp_lim(int ph);   return (ph == 2) ? 1 : 0; endfunction
    function automatic int exp_flt(int ph);   return (ph == 3) ? 1 : 0; endfunction
    function automatic int sat_inc(int c);    return (c < CMAX) ? c + 1 : c; endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_s1 <= 0; m_s2 <= 0; m_ph <= 0; m_left <= 0; m_cnt <= 0;
        end else begin
            m_s1 <= oc_in;
            m_s2 <= m_s1;
            if (!en) m_ph <= 0;
            else case (m_ph)
                0: m_ph <= 1;
                1: if (m_s2) begin m_ph <= 2; m_left <= LIM; end
                2: if (!m_s2) m_ph <= 1;
                   else if (m_left == 1) begin m_ph <= 3; m_left <= RET; m_cnt <= sat_inc(m_cnt); end
                   else m_left <= m_left - 1;
                default: if (m_left == 1) begin m_ph <= 2; m_left <= LIM; end
                   else m_left <= m_left - 1;
            endcase
        end
    end

    task automatic chk(string req, int got, int exp);
        n_tests++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s got=%0d exp=%0d at %0t", req, got, exp, $time);
        end
    endtask

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (cmp_on) begin
            chk("R9 model reg_on",      int'(reg_on),      exp_on(m_ph));
            chk("R4 model limiting",    int'(limiting),    exp_lim(m_ph));
            chk("R6 model fault",       int'(fault),       exp_flt(m_ph));
            chk("R7 model fault_count", int'(fault_count), m_cnt);
        end
    end

    task automatic tick(int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        int unused;
        unused = $urandom(32'h5eed_0cdc);
        tick(3);
        // R1: reset state
        chk("R1 reg_on", int'(reg_on), 0);
        chk("R1 limiting", int'(limiting), 0);
        chk("R1 fault", int'(fault), 0);
        chk("R1 count", int'(fault_count), 0);
        rst_n = 1'b1;
        cmp_on = 1'b1;
        tick(2);
        chk("R8 idle with en low", int'(reg_on), 0);
        en = 1'b1;
        tick(1);
        chk("R2 reg_on after enable", int'(reg_on), 1);
        tick(3);
        // R3: synchronizer latency
        oc_in = 1'b1;
        tick(2);
        chk("R3 no clamp after 2 edges", int'(limiting), 0);
        tick(1);
        chk("R3 clamp after 3 edges", int'(limiting), 1);
        chk("R3 still on", int'(reg_on), 1);
        // R5: shutdown after LIM clamp cycles
        tick(LIM - 1);
        chk("R5 clamp last cycle", int'(limiting), 1);
        tick(1);
        chk("R5 off", int'(reg_on), 0);
        chk("R5 fault", int'(fault), 1);
        chk("R7 count 1", int'(fault_count), 1);
        // R6: retry after RET cycles
        tick(RET - 1);
        chk("R6 fault last cycle", int'(fault), 1);
        tick(1);
        chk("R6 probe on", int'(reg_on), 1);
        chk("R6 probe clamp", int'(limiting), 1);
        // R4: clear during probe
        oc_in = 1'b0;
        tick(2);
        chk("R4 clamp held during sync", int'(limiting), 1);
        tick(1);
        chk("R4 clamp released", int'(limiting), 0);
        chk("R4 still on", int'(reg_on), 1);
        // R7: repeated hiccups saturate the count
        oc_in = 1'b1;
        tick(3 + (CMAX + 2) * (LIM + RET));
        chk("R7 saturated", int'(fault_count), CMAX);
        // R8: disable forces off, count kept
        en = 1'b0;
        tick(1);
        chk("R8 reg_on", int'(reg_on), 0);
        chk("R8 limiting", int'(limiting), 0);
        chk("R8 fault", int'(fault), 0);
        chk("R8 count kept", int'(fault_count), CMAX);
        en = 1'b1;
        tick(2);
        chk("R8 fresh clamp after enable", int'(limiting), 1);
        tick(LIM - 1);
        chk("R8 timer restarted full", int'(limiting), 1);
        // random phase after a fresh reset
        oc_in = 1'b0;
        rst_n = 1'b0;
        tick(2);
        rst_n = 1'b1;
        for (int i = 0; i < 200; i++) begin
            oc_in = ($urandom_range(0, 2) != 0) ? 1'b1 : 1'b0;
            en    = ($urandom_range(0, 15) != 0) ? 1'b1 : 1'b0;
            tick($urandom_range(1, 60));
        end
        cmp_on = 1'b0;
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // watchdog
    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end
endmodule